// File: doc/BRIEF.md
# Hierarchical Priority Interrupt Arbiter

This block picks one winner out of 26 interrupt requests that have already been qualified upstream. The sources are split into four groups of six and two global sources. Each group feeds a group unit. In that unit, four inputs are ranked by a software-supplied configuration byte, and two fixed inputs always rank below those four. A top-level unit then ranks the four group winners by its own configuration byte. The two global sources sit below every other request.

The selection logic is purely combinational. Its result is captured once per clock into three outputs: a one-hot service vector that carries only the winning source, the binary index of that source, and a valid flag. The block has no pending latches, register decode or vector generation. It is meant to sit between a pending register and the logic that signals the processor.

Top module: `arb_top`

## Requirements
- R1: Source k maps to group k/6 with local input k%6 for k<24. Local inputs 0..3 are programmable and local inputs 4..5 are fixed. Sources 24 and 25 attach directly to the top-level unit.
- R2: In group g, local input i (0..3) takes its rank from bits slv_cfg_i[g*8+2*i +: 2]. Among the active programmable inputs, the one with the numerically lowest rank wins. On equal ranks, the lower local index wins.
- R3: A fixed input of a group (local 4 or 5) wins its group only when none of that group's programmable inputs is active. When both fixed inputs are active, local 4 beats local 5.
- R4: Group g takes its top-level rank from mst_cfg_i[2*g +: 2]. Among the groups that have a winner, the lowest rank wins. On equal ranks, the lower group number wins.
- R5: Source 24 wins only when sources 0..23 are all idle. Source 25 wins only when sources 0..24 are all idle.
- R6: Whenever any request is active, grant_o has exactly one bit set, at the winning source. win_idx_o equals that bit position, and win_vld_o is 1.
- R7: With no active request, grant_o is all zero, win_idx_o is 0 and win_vld_o is 0.
- R8: The outputs show the result for the inputs present at the previous rising clock edge. While reset is held, and right after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 26 | Qualified request vector, bit k is source k |
| slv_cfg_i | input | 32 | Group rank configuration, 8 bits per group |
| mst_cfg_i | input | 8 | Top-level rank configuration, 2 bits per group |
| grant_o | output | 26 | One-hot service vector, winner only |
| win_idx_o | output | 5 | Index of the winning source |
| win_vld_o | output | 1 | High when some request is active |

## Verification
The bench builds the block with its default parameters: four groups of four ranked and two fixed inputs, 2-bit ranks, and two global sources. At this size, two whole groups can be swept exhaustively, covering all 256 rank bytes against all 64 request patterns. The top level gets the same treatment, with all 256 rank bytes against every combination of group activity and global requests. Every tie, and the case where a fixed input wins, is therefore visited. Random full-width vectors then mix all levels against an arithmetic sort-key model.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DEF_GRP_NUM  = 4;
  localparam int DEF_GRP_PROG = 4;
  localparam int DEF_GRP_FIX  = 2;
  localparam int DEF_TOP_FIX  = 2;
  localparam int DEF_RANK_W   = 2;
endpackage

// File: rtl/rank_pick.sv
module rank_pick #(
  parameter int N_PROG = 4,
  parameter int N_FIX  = 2,
  parameter int RANK_W = 2,
  localparam int N_ALL = N_PROG + N_FIX,
  localparam int SEL_W = $clog2(N_ALL),
  localparam int N_LVL = 1 << RANK_W
) (
  input  logic [N_PROG-1:0]        prog_req,
  input  logic [N_PROG*RANK_W-1:0] rank_cfg,
  input  logic [N_FIX-1:0]         fix_req,
  output logic                     hit,
  output logic [SEL_W-1:0]         sel
);
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int lvl = 0; lvl < N_LVL; lvl++) begin
      for (int i = 0; i < N_PROG; i++) begin
        if (!hit && prog_req[i] &&
            rank_cfg[i*RANK_W +: RANK_W] == RANK_W'(lvl)) begin
          hit = 1'b1;
          sel = SEL_W'(i);
        end
      end
    end
    for (int f = 0; f < N_FIX; f++) begin
      if (!hit && fix_req[f]) begin
        hit = 1'b1;
        sel = SEL_W'(N_PROG + f);
      end
    end
  end
endmodule

// File: rtl/arb_group.sv
module arb_group #(
  parameter int N_PROG = 4,
  parameter int N_FIX  = 2,
  parameter int RANK_W = 2,
  localparam int N_ALL = N_PROG + N_FIX,
  localparam int SEL_W = $clog2(N_ALL)
) (
  input  logic [N_ALL-1:0]         req,
  input  logic [N_PROG*RANK_W-1:0] cfg,
  output logic                     hit,
  output logic [SEL_W-1:0]         sel
);
  rank_pick #(.N_PROG(N_PROG), .N_FIX(N_FIX), .RANK_W(RANK_W)) u_pick (
    .prog_req (req[N_PROG-1:0]),
    .rank_cfg (cfg),
    .fix_req  (req[N_ALL-1:N_PROG]),
    .hit      (hit),
    .sel      (sel)
  );
endmodule

// File: rtl/arb_root.sv
module arb_root #(
  parameter int N_GRP   = 4,
  parameter int GRP_SZ  = 6,
  parameter int N_FIX   = 2,
  parameter int RANK_W  = 2,
  parameter int LOC_W   = 3,
  parameter int IDX_W   = 5,
  localparam int N_ALL  = N_GRP + N_FIX,
  localparam int SEL_W  = $clog2(N_ALL),
  localparam int FIX_BASE = N_GRP * GRP_SZ
) (
  input  logic [N_GRP-1:0]            grp_hit,
  input  logic [N_GRP-1:0][LOC_W-1:0] grp_sel,
  input  logic [N_FIX-1:0]            fix_req,
  input  logic [N_GRP*RANK_W-1:0]     cfg,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  logic [SEL_W-1:0] top_sel;
  int unsigned      idx_tmp;

  rank_pick #(.N_PROG(N_GRP), .N_FIX(N_FIX), .RANK_W(RANK_W)) u_pick (
    .prog_req (grp_hit),
    .rank_cfg (cfg),
    .fix_req  (fix_req),
    .hit      (hit),
    .sel      (top_sel)
  );

  always_comb begin
    idx_tmp = 0;
    for (int g = 0; g < N_GRP; g++) begin
      if (top_sel == SEL_W'(g)) idx_tmp = g * GRP_SZ + int'(grp_sel[g]);
    end
    for (int f = 0; f < N_FIX; f++) begin
      if (top_sel == SEL_W'(N_GRP + f)) idx_tmp = FIX_BASE + f;
    end
    idx = hit ? IDX_W'(idx_tmp) : '0;
  end
endmodule

// File: rtl/arb_top.sv
module arb_top #(
  parameter int N_GRP   = arb_pkg::DEF_GRP_NUM,
  parameter int G_PROG  = arb_pkg::DEF_GRP_PROG,
  parameter int G_FIX   = arb_pkg::DEF_GRP_FIX,
  parameter int T_FIX   = arb_pkg::DEF_TOP_FIX,
  parameter int RANK_W  = arb_pkg::DEF_RANK_W,
  localparam int GRP_SZ = G_PROG + G_FIX,
  localparam int N_SRC  = N_GRP * GRP_SZ + T_FIX,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int LOC_W  = $clog2(GRP_SZ),
  localparam int GCFG_W = G_PROG * RANK_W,
  localparam int TCFG_W = N_GRP * RANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_GRP*GCFG_W-1:0] slv_cfg_i,
  input  logic [TCFG_W-1:0]       mst_cfg_i,
  output logic [N_SRC-1:0]        grant_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output logic                    win_vld_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [N_GRP-1:0]            grp_hit;
  logic [N_GRP-1:0][LOC_W-1:0] grp_sel;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    arb_group #(.N_PROG(G_PROG), .N_FIX(G_FIX), .RANK_W(RANK_W)) u_grp (
      .req (req_i[g*GRP_SZ +: GRP_SZ]),
      .cfg (slv_cfg_i[g*GCFG_W +: GCFG_W]),
      .hit (grp_hit[g]),
      .sel (grp_sel[g])
    );
  end

  logic             win_hit;
  logic [IDX_W-1:0] win_idx;

  arb_root #(
    .N_GRP(N_GRP), .GRP_SZ(GRP_SZ), .N_FIX(T_FIX), .RANK_W(RANK_W),
    .LOC_W(LOC_W), .IDX_W(IDX_W)
  ) u_root (
    .grp_hit (grp_hit),
    .grp_sel (grp_sel),
    .fix_req (req_i[N_SRC-1 -: T_FIX]),
    .cfg     (mst_cfg_i),
    .hit     (win_hit),
    .idx     (win_idx)
  );

  logic [N_SRC-1:0] grant_d;
  always_comb begin
    grant_d = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (win_hit && win_idx == IDX_W'(k)) grant_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_o   <= '0;
      win_idx_o <= '0;
      win_vld_o <= 1'b0;
    end else begin
      grant_o   <= grant_d;
      win_idx_o <= win_idx;
      win_vld_o <= win_hit;
    end
  end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N_SRC = 26,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] grant_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic             win_vld_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R6
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o == (grant_o != '0)); // R6
  AST_IDX_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> grant_o[win_idx_o]); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (!win_vld_o && win_idx_o == '0)); // R7
  AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> win_vld_o); // R8
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant_o & ~$past(req_i)) == '0)); // R8
  AST_LAST_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[N_SRC-2:0] != '0) |=> !grant_o[N_SRC-1]); // R5
endmodule

bind arb_top arb_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_i     (req_i),
  .grant_o   (grant_o),
  .win_idx_o (win_idx_o),
  .win_vld_o (win_vld_o)
);

// File: tb/tb_arb_top.sv
module tb_arb_top;
  localparam int NS = 26;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] req;
  logic [31:0]   scfg;
  logic [7:0]    mcfg;
  logic [NS-1:0] grant;
  logic [4:0]    widx;
  logic          wvld;

  int checks;
  int failures;

  arb_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .slv_cfg_i(scfg), .mst_cfg_i(mcfg),
    .grant_o(grant), .win_idx_o(widx), .win_vld_o(wvld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Sort key: smaller key wins
  function automatic int src_key(int k, logic [31:0] sc, logic [7:0] mc);
    int g, l, gk, lk;
    if (k >= 24) return (16 + (k - 24)) * 32;
    g  = k / 6;
    l  = k % 6;
    gk = int'(mc[2*g +: 2]) * 4 + g;
    if (l < 4) lk = int'(sc[g*8 + 2*l +: 2]) * 4 + l;
    else       lk = 16 + (l - 4);
    return gk * 32 + lk;
  endfunction

  task automatic expect_now(string tag);
    int best, bidx;
    logic [NS-1:0] eg;
    logic          ev;
    best = 1 << 20; bidx = 0; ev = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (req[k] && src_key(k, scfg, mcfg) < best) begin
        best = src_key(k, scfg, mcfg); bidx = k; ev = 1'b1;
      end
    end
    eg = ev ? (NS'(1) << bidx) : '0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant !== eg || widx !== 5'(bidx) || wvld !== ev) begin
      failures++;
      $display("FAIL %s req=%h grant=%h idx=%0d vld=%b expected grant=%h idx=%0d vld=%b",
               tag, req, grant, widx, wvld, eg, bidx, ev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; req = '1; scfg = '0; mcfg = '0;
    repeat (3) @(negedge clk);
    checks++; // R8 reset state
    if (grant !== '0 || widx !== '0 || wvld !== 1'b0) begin
      failures++;
      $display("FAIL R8 reset grant=%h idx=%0d vld=%b expected 0 0 0", grant, widx, wvld);
    end
    req = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 idle
    req = '0; scfg = 32'hA5C3_1E77; mcfg = 8'h1B;
    expect_now("R7");

    // R8 registered timing: output holds old value until the edge
    req = NS'(1) << 13;
    @(posedge clk); @(negedge clk);
    req = NS'(1) << 2;
    #3;
    checks++;
    if (widx !== 5'd13 || grant !== (NS'(1) << 13)) begin
      failures++;
      $display("FAIL R8 before edge idx=%0d expected 13", widx);
    end
    @(negedge clk);

    // R1 R2 R3: exhaustive on groups 0 and 2
    for (int g = 0; g < 4; g += 2) begin
      for (int c = 0; c < 256; c++) begin
        for (int p = 0; p < 64; p++) begin
          req = '0;
          req[g*6 +: 6] = 6'(p);
          scfg = 32'h3C96_E14B;
          scfg[g*8 +: 8] = 8'(c);
          mcfg = 8'(c ^ 8'h5A);
          expect_now("R1/R2/R3");
        end
      end
    end

    // R4 R5: top-level sweep
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 64; p++) begin
        req = '0;
        for (int g = 0; g < 4; g++) begin
          if (p[g]) req[g*6 + ((c + g) % 6)] = 1'b1;
        end
        req[24] = p[4];
        req[25] = p[5];
        mcfg = 8'(c);
        scfg = 32'h9B27_64D1;
        expect_now("R4/R5");
      end
    end

    // R6: random full-width mixes
    for (int n = 0; n < 3000; n++) begin
      req  = NS'($urandom) & NS'($urandom);
      scfg = $urandom;
      mcfg = 8'($urandom);
      expect_now("R6");
    end

    // R5 corner: only globals
    req = '0; req[24] = 1'b1; req[25] = 1'b1;
    expect_now("R5");
    req = '0; req[25] = 1'b1;
    expect_now("R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule